// File: doc/BRIEF.md
# Quarter-Wave Table Sine Oscillator

This block is a numerically controlled oscillator. It produces a signed digital sine wave. Each sample cycle, a phase accumulator adds a programmable tuning word to itself, so the output frequency is the tuning word times the sample rate divided by 2^32. The upper phase bits select a sine value.

Only one quadrant of the sine period is stored, as a table that is computed when the design is elaborated. The two most significant phase bits rebuild the other three quadrants. One selects whether the table is read forwards or backwards. The other selects whether the magnitude is negated.

All state advances only on cycles where a shared sample enable is high. The sample rate can therefore be any fraction of the system clock. The tuning word may change at any time, and the change does not disturb the current phase.

Top module: `nco_qwave_sine`

## Requirements
- R1: After reset, `valid_o` is 0, `sample_o` is 0, and the phase is zero, so the first sample produced is the one for phase 0.
- R2: Each cycle with `sample_en_i` high adds `ftw_i` to the 32-bit phase, modulo 2^32.
- R3: For a phase whose top 10 bits read k, the sample is round(32767 * sin(2*pi*(k+0.5)/1024)), as 16-bit two's complement. No sample is ever zero.
- R4: When phase bit 30 is set (second and fourth quadrants), the 8-bit table address taken from phase bits 29:22 is bit-inverted, so the table is read in reverse order.
- R5: When phase bit 31 is set (third and fourth quadrants), the sample is the negated table magnitude.
- R6: On cycles with `sample_en_i` low, neither the phase nor any output changes.
- R7: A sample appears two enabled cycles after its phase is used. `valid_o` first rises on the second enabled cycle after reset.
- R8: A new `ftw_i` is used from the next enabled cycle onward, and the phase is not reset, so the phase stays continuous.
- R9: `sample_o` stays within -32767 to +32767; the value -32768 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_en_i | input | 1 | Sample clock enable; all state advances only while high |
| ftw_i | input | 32 | Frequency tuning word (phase increment per sample) |
| sample_o | output | 16 | Signed sine sample |
| valid_o | output | 1 | High once the pipeline holds a real sample |

## Verification
The bench sweeps a one-table-step-per-sample tuning word through more than a full period. This compares every table entry in all four quadrants. A wrong address mirror would show up as a jump at the quadrant edges. A wrong sign would show up as a positive value in the second half-wave.

A large tuning word close to 2^32 forces wraparound of the accumulator. The tuning word is also changed mid-stream, which exposes a design that resets the phase or applies the new word one cycle late.

Enable is also gapped, and the outputs are compared to their previous values on the idle cycles. Any register that ignores the enable would move there. Reset in the middle of a run checks that the phase returns to zero and that the two-cycle latency of `valid_o` holds.

// File: rtl/nco_pkg.sv
package nco_pkg;
  // Quarter-wave magnitude at half-LSB offset, Taylor series (elaboration only)
  function automatic int qsin_mag(int idx, int addr_w, int mag_w);
    real x, term, acc;
    x    = (real'(idx) + 0.5) * 1.5707963267948966 / real'(1 << addr_w);
    term = x;
    acc  = x;
    for (int n = 1; n < 12; n++) begin
      term = -term * x * x / real'((2 * n) * (2 * n + 1));
      acc  = acc + term;
    end
    return $rtoi(acc * real'((1 << mag_w) - 1) + 0.5);
  endfunction
endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int PHASE_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [PHASE_W-1:0] ftw_i,
  output logic [PHASE_W-1:0] phase_o
);
  logic [PHASE_W-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   phase_q <= '0;
    else if (en_i) phase_q <= phase_q + ftw_i;
  end

  assign phase_o = phase_q;

  // R6
  phase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(phase_q));
endmodule

// File: rtl/nco_quarter_rom.sv
module nco_quarter_rom #(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 8,
  parameter int MAG_W   = 15
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [PHASE_W-1:0] phase_i,
  output logic [MAG_W-1:0]   mag_o,
  output logic               neg_o,
  output logic               vld_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [MAG_W-1:0]  table_w [DEPTH];
  logic [ADDR_W-1:0] addr_raw, addr;
  logic [MAG_W-1:0]  mag_q;
  logic              neg_q, vld_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_tab
    localparam int VAL = nco_pkg::qsin_mag(g, ADDR_W, MAG_W);
    assign table_w[g] = VAL[MAG_W-1:0];
  end

  assign addr_raw = phase_i[PHASE_W-3 -: ADDR_W];
  // odd quadrants read the table backwards
  assign addr     = phase_i[PHASE_W-2] ? ~addr_raw : addr_raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mag_q <= '0;
      neg_q <= 1'b0;
      vld_q <= 1'b0;
    end else if (en_i) begin
      mag_q <= table_w[addr];
      neg_q <= phase_i[PHASE_W-1];
      vld_q <= 1'b1;
    end
  end

  assign mag_o = mag_q;
  assign neg_o = neg_q;
  assign vld_o = vld_q;

  // R3
  mag_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> (mag_q != '0));
endmodule

// File: rtl/nco_sign_stage.sv
module nco_sign_stage #(
  parameter int MAG_W = 15,
  localparam int OUT_W = MAG_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic [MAG_W-1:0]        mag_i,
  input  logic                    neg_i,
  input  logic                    vld_i,
  output logic signed [OUT_W-1:0] sample_o,
  output logic                    valid_o
);
  logic signed [OUT_W-1:0] pos_w, sample_q;
  logic                    valid_q;

  assign pos_w = $signed({1'b0, mag_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_q <= '0;
      valid_q  <= 1'b0;
    end else if (en_i) begin
      sample_q <= neg_i ? -pos_w : pos_w;
      valid_q  <= vld_i;
    end
  end

  assign sample_o = sample_q;
  assign valid_o  = valid_q;

  // R5
  sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && vld_i) |=> (sample_q[OUT_W-1] == $past(neg_i)));
  // R9
  range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_q != {1'b1, {MAG_W{1'b0}}});
  // R6
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(sample_q) && $stable(valid_q)));
endmodule

// File: rtl/nco_qwave_sine.sv
module nco_qwave_sine #(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 8,
  parameter int MAG_W   = 15,
  localparam int OUT_W  = MAG_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sample_en_i,
  input  logic [PHASE_W-1:0]      ftw_i,
  output logic signed [OUT_W-1:0] sample_o,
  output logic                    valid_o
);
  logic [PHASE_W-1:0] phase_w;
  logic [MAG_W-1:0]   mag_w;
  logic               neg_w, vld_w;

  nco_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(sample_en_i),
    .ftw_i(ftw_i), .phase_o(phase_w)
  );

  nco_quarter_rom #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .MAG_W(MAG_W)) u_rom (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(sample_en_i), .phase_i(phase_w),
    .mag_o(mag_w), .neg_o(neg_w), .vld_o(vld_w)
  );

  nco_sign_stage #(.MAG_W(MAG_W)) u_sign (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(sample_en_i),
    .mag_i(mag_w), .neg_i(neg_w), .vld_i(vld_w),
    .sample_o(sample_o), .valid_o(valid_o)
  );

  // R7
  valid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> ($past(sample_en_i) && $past(vld_w)));
endmodule

// File: tb/sim_nco_qwave_sine.sv
`timescale 1ns/1ps
module sim_nco_qwave_sine;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               en = 1'b0;
  logic [31:0]        ftw = '0;
  logic signed [15:0] sample;
  logic               valid;

  int    n_chk = 0, n_err = 0;
  string tag = "R3";
  logic  [31:0] model_ph = '0;
  logic signed [15:0] exp_q[$];
  logic  en_seen = 1'b0;
  logic signed [15:0] last_sample = '0;
  logic  last_valid = 1'b0;

  always #2 clk = ~clk;

  nco_qwave_sine u0 (
    .clk_i(clk), .rst_ni(rst_n), .sample_en_i(en), .ftw_i(ftw),
    .sample_o(sample), .valid_o(valid)
  );

  always @(posedge clk) en_seen <= en;

  function automatic logic signed [15:0] exp_sample(logic [31:0] p);
    int  k;
    real a, s;
    int  m;
    k = int'(p[31:22]);
    a = (real'(k) + 0.5) * 6.283185307179586 / 1024.0;
    s = $sin(a);
    if (s < 0.0) s = -s;
    m = $rtoi(s * 32767.0 + 0.5);
    return (k >= 512) ? 16'(-m) : 16'(m);
  endfunction

  task automatic check(string t, logic signed [31:0] act, logic signed [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", t, act, expv);
    end
  endtask

  // driver: one cycle, pushes expected sample when enabled
  task automatic step(logic e, logic [31:0] w);
    @(negedge clk);
    en  = e;
    ftw = w;
    if (e) begin
      exp_q.push_back(exp_sample(model_ph));
      model_ph = model_ph + w;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    exp_q.delete();
    model_ph = '0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #0.5;
      if (rst_n && valid) begin
        if (en_seen) begin
          if (exp_q.size() == 0) check({tag, " queue empty"}, 1, 0);
          else check(tag, sample, exp_q.pop_front());
        end else if (last_valid) begin
          check("R6 hold", sample, last_sample);
        end
      end
      last_sample = sample;
      last_valid  = valid;
    end
  end

  initial begin
    #400000;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    // R1 reset state
    #1;
    check("R1 valid", valid, 0);
    check("R1 sample", sample, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 valid after release", valid, 0);

    // R7 latency
    step(1, 32'h0040_0000);
    @(posedge clk); #1;
    check("R7 valid after 1", valid, 0);
    step(1, 32'h0040_0000);
    @(posedge clk); #1;
    check("R7 valid after 2", valid, 1);
    check("R1 first sample phase 0", sample, 101);

    // R3 R4 R5: full sweep, one table step per sample
    tag = "R3 R4 R5 sweep";
    for (int i = 0; i < 1100; i++) step(1, 32'h0040_0000);

    // R6: gapped enable with odd tuning word
    tag = "R6 R2 gapped";
    for (int i = 0; i < 300; i++) step((i % 3) == 0, 32'h0123_4567);

    // R8: tuning word changes without phase reset
    tag = "R8 retune";
    for (int i = 0; i < 200; i++) step(1, 32'h0765_4321);
    for (int i = 0; i < 200; i++) step(i[0], 32'h0009_abcd);

    // R2: wraparound with near-2^32 step
    tag = "R2 wrap";
    for (int i = 0; i < 400; i++) step(1, 32'hFFC0_0001);

    // R1: reset mid-run restarts at phase 0
    do_reset();
    tag = "R1 restart";
    check("R1 valid after mid reset", valid, 0);
    for (int i = 0; i < 50; i++) step(1, 32'h0200_0000);
    step(0, 32'h0);
    step(0, 32'h0);
    @(negedge clk);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule